// File: doc/BRIEF.md
# Seven-Source Interrupt Flag and Enable Unit

This block gathers the interrupt sources of a peripheral controller into one request line. It watches four handshake control lines for edges, takes single-cycle event pulses from a shift unit and two timers, and latches each event in its own bit of a seven-bit flag register. A matching seven-bit enable register chooses which latched events may drive the active-low request output. Both registers are reached through byte-wide CPU accesses. In each write, the top data bit chooses whether the bits marked 1 in the lower seven are set or cleared. Bits marked 0 are left alone.

A third byte register, the line-control register, chooses the active edge of the two edge-only lines. It also gives each of the two dual-purpose lines a three-bit mode: edge input with the flag cleared by a port data access, independent edge input, or driven output. The port data paths and timer counters are outside this block. It only receives a one-cycle strobe for each port data access and each timer timeout.

Top module: `irqFlagUnit`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it, all flags, enables and line-control bits read 0, `irqN` is 1 and both line-drive enables are 0. Line levels present during reset never produce a flag.
- R2: Reading with `regSel`=00 returns the flags in bits 6:0, in this order: bit0 A2 line, bit1 A1 line, bit2 shift event, bit3 B2 line, bit4 B1 line, bit5 timer 2, bit6 timer 1. Bit 7 reads 1 exactly when some flag and its enable are both 1.
- R3: `irqN` is 0 exactly when some flag and its enable are both 1. It follows the registers with no added delay.
- R4: A write with `regSel`=00 and data bit 7 = 0 clears every flag whose data bit is 1. With data bit 7 = 1 it sets those flags instead. Flags with data bit 0 keep their value.
- R5: A write with `regSel`=01 enables the sources whose data bit is 1 when data bit 7 is 1, and disables them when bit 7 is 0. Other enables are unchanged. Reading with `regSel`=01 returns the enables in bits 6:0 and a constant 1 in bit 7.
- R6: Line-control bit 0 sets the active edge of line A1 and bit 4 that of line B1: 0 selects falling, 1 selects rising. An edge of the opposite direction sets no flag.
- R7: Line-control bits 3:1 form the A2 mode and bits 7:5 the B2 mode. Modes 000 and 001 flag falling edges, and modes 010 and 011 flag rising edges.
- R8: In modes 000 and 010, a `portAAccess` (or `portBAccess`) pulse clears the A2 (or B2) flag. In the independent modes 001 and 011, the pulse leaves that flag unchanged.
- R9: In modes 1xx the line is an output, with its drive enable at 1. Mode 110 drives 0 and modes 100, 101 and 111 drive 1. Edges on the line's input then set no flag.
- R10: An edge, `shiftDone`, `t1Timeout` or `t2Timeout` in a cycle sets its flag at the next clock edge. This holds even if a flag write or port access in that same cycle would clear it.
- R11: `regSel`=10 writes and reads back the line-control register. `regSel`=11 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe for the selected register |
| regSel | input | 2 | Register select: 00 flags, 01 enables, 10 line control, 11 unused |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register (combinational) |
| portAAccess | input | 1 | One-cycle strobe: port A data was accessed |
| portBAccess | input | 1 | One-cycle strobe: port B data was accessed |
| ctlA1 | input | 1 | Edge-only handshake line A1 |
| ctlA2In | input | 1 | Dual-purpose line A2, input side |
| ctlB1 | input | 1 | Edge-only handshake line B1 |
| ctlB2In | input | 1 | Dual-purpose line B2, input side |
| shiftDone | input | 1 | Shift unit event pulse |
| t1Timeout | input | 1 | Timer 1 timeout pulse |
| t2Timeout | input | 1 | Timer 2 timeout pulse |
| irqN | output | 1 | Active-low interrupt request |
| ctlA2Out | output | 1 | Level driven on line A2 in output modes |
| ctlA2OutEn | output | 1 | Line A2 drive enable |
| ctlB2Out | output | 1 | Level driven on line B2 in output modes |
| ctlB2OutEn | output | 1 | Line B2 drive enable |

## Verification
The properties assume that the line inputs are already synchronous to `clk`. They also assume that the event strobes are pulses sampled at the rising edge, not levels to be counted. The bench drives every input just after the falling edge, so each level is stable for a whole cycle before the edge that samples it. The checks on timer 1 flag clearing and enable updates rely on a write being seen in one cycle only. The bench therefore keeps `wrEn` high for exactly one cycle per access, including in the random phase, where writes, strobes and line levels are mixed freely.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = REG_W - 1;
  localparam int NUM_LINES = 4;

  // flag bit positions (shared with software decoding)
  localparam int BIT_A2 = 0;
  localparam int BIT_A1 = 1;
  localparam int BIT_SH = 2;
  localparam int BIT_B2 = 3;
  localparam int BIT_B1 = 4;
  localparam int BIT_T2 = 5;
  localparam int BIT_T1 = 6;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'b00,
    SEL_EN   = 2'b01,
    SEL_CTL  = 2'b10,
    SEL_NONE = 2'b11
  } regSel_e;

  typedef struct packed {
    logic               flagWr;
    logic               enWr;
    logic               ctlWr;
    logic               setNotClr;
    logic [NUM_SRC-1:0] mask;
    logic [REG_W-1:0]   data;
    logic [NUM_SRC-1:0] portClr;
  } strobes_t;
endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqPkg::*;
(
  input  logic              wrEn,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic              portAAccess,
  input  logic              portBAccess,
  input  logic [2:0]        modeA2,
  input  logic [2:0]        modeB2,
  output strobes_t          stb
);
  logic clrA2, clrB2;

  // port access clears the dual-purpose line flag only in non-independent input modes
  assign clrA2 = portAAccess && !modeA2[2] && !modeA2[0];
  assign clrB2 = portBAccess && !modeB2[2] && !modeB2[0];

  always_comb begin
    stb = '0;
    stb.flagWr    = wrEn && (regSel_e'(regSel) == SEL_FLAG);
    stb.enWr      = wrEn && (regSel_e'(regSel) == SEL_EN);
    stb.ctlWr     = wrEn && (regSel_e'(regSel) == SEL_CTL);
    stb.setNotClr = wrData[REG_W-1];
    stb.mask      = wrData[NUM_SRC-1:0];
    stb.data      = wrData;
    stb.portClr[BIT_A2] = clrA2;
    stb.portClr[BIT_B2] = clrB2;
  end
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [1:0]         regSel,
  input  logic [NUM_LINES-1:0] lineIn,   // {B2, B1, A2, A1}
  input  logic               shiftDone,
  input  logic               t1Timeout,
  input  logic               t2Timeout,
  output logic [REG_W-1:0]   rdData,
  output logic               irqN,
  output logic [2:0]         modeA2,
  output logic [2:0]         modeB2,
  output logic               ctlA2Out,
  output logic               ctlA2OutEn,
  output logic               ctlB2Out,
  output logic               ctlB2OutEn,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] enQ
);
  logic [REG_W-1:0]     ctlQ;
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] linePol;
  logic [NUM_LINES-1:0] lineArm;
  logic [NUM_LINES-1:0] lineEdge;
  logic [NUM_SRC-1:0]   events;
  logic [NUM_SRC-1:0]   flagD;
  logic [NUM_SRC-1:0]   enD;
  logic                 pending;

  assign modeA2 = ctlQ[3:1];
  assign modeB2 = ctlQ[7:5];

  // polarity and arming per line: index 0 A1, 1 A2, 2 B1, 3 B2
  assign linePol = {modeB2[1], ctlQ[4], modeA2[1], ctlQ[0]};
  assign lineArm = {!modeB2[2], 1'b1, !modeA2[2], 1'b1};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINES; gi++) begin : gEdge
      logic riseHit, fallHit;
      assign riseHit = !prevQ[gi] && lineIn[gi];
      assign fallHit = prevQ[gi] && !lineIn[gi];
      assign lineEdge[gi] = lineArm[gi] && (linePol[gi] ? riseHit : fallHit);
    end
  endgenerate

  always_comb begin
    events = '0;
    events[BIT_A1] = lineEdge[0];
    events[BIT_A2] = lineEdge[1];
    events[BIT_B1] = lineEdge[2];
    events[BIT_B2] = lineEdge[3];
    events[BIT_SH] = shiftDone;
    events[BIT_T2] = t2Timeout;
    events[BIT_T1] = t1Timeout;
  end

  always_comb begin
    flagD = flagQ;
    if (stb.flagWr) begin
      if (stb.setNotClr) flagD = flagD | stb.mask;
      else               flagD = flagD & ~stb.mask;
    end
    flagD = flagD & ~stb.portClr;
    flagD = flagD | events;   // a new event wins over any clear
  end

  always_comb begin
    enD = enQ;
    if (stb.enWr) begin
      if (stb.setNotClr) enD = enQ | stb.mask;
      else               enD = enQ & ~stb.mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      ctlQ  <= '0;
      prevQ <= lineIn;
    end else begin
      flagQ <= flagD;
      enQ   <= enD;
      prevQ <= lineIn;
      if (stb.ctlWr) ctlQ <= stb.data;
    end
  end

  assign pending = |(flagQ & enQ);
  assign irqN    = !pending;

  always_comb begin
    unique case (regSel_e'(regSel))
      SEL_FLAG: rdData = {pending, flagQ};
      SEL_EN:   rdData = {1'b1, enQ};
      SEL_CTL:  rdData = ctlQ;
      default:  rdData = '0;
    endcase
  end

  // output drive for the dual-purpose lines
  assign ctlA2OutEn = modeA2[2];
  assign ctlA2Out   = !(modeA2 == 3'b110);
  assign ctlB2OutEn = modeB2[2];
  assign ctlB2Out   = !(modeB2 == 3'b110);
endmodule

// File: rtl/irqFlagUnit.sv
module irqFlagUnit
  import irqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       regSel,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             portAAccess,
  input  logic             portBAccess,
  input  logic             ctlA1,
  input  logic             ctlA2In,
  input  logic             ctlB1,
  input  logic             ctlB2In,
  input  logic             shiftDone,
  input  logic             t1Timeout,
  input  logic             t2Timeout,
  output logic             irqN,
  output logic             ctlA2Out,
  output logic             ctlA2OutEn,
  output logic             ctlB2Out,
  output logic             ctlB2OutEn
);
  strobes_t           stb;
  logic [2:0]         modeA2, modeB2;
  logic [NUM_SRC-1:0] flagQ, enQ;

  irqCtrl uCtrl (
    .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .portAAccess(portAAccess), .portBAccess(portBAccess),
    .modeA2(modeA2), .modeB2(modeB2), .stb(stb)
  );

  irqDatapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel),
    .lineIn({ctlB2In, ctlB1, ctlA2In, ctlA1}),
    .shiftDone(shiftDone), .t1Timeout(t1Timeout), .t2Timeout(t2Timeout),
    .rdData(rdData), .irqN(irqN), .modeA2(modeA2), .modeB2(modeB2),
    .ctlA2Out(ctlA2Out), .ctlA2OutEn(ctlA2OutEn),
    .ctlB2Out(ctlB2Out), .ctlB2OutEn(ctlB2OutEn),
    .flagQ(flagQ), .enQ(enQ)
  );
endmodule

// File: rtl/irqFlagChk.sv
module irqFlagChk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] regSel,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       irqN,
  input logic       t1Timeout,
  input logic [6:0] flagQ,
  input logic [6:0] enQ
);
  // R1: reset empties both registers
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rstN |=> (flagQ == 7'd0 && enQ == 7'd0));

  // R3: request line agrees with the master bit on flag reads
  assert_irq_master_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'b00) |-> (irqN == !rdData[7]));

  // R5: enable register always reads bit 7 as one
  assert_en_bit7_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'b01) |-> rdData[7]);

  // R5: unmasked enables keep their value across an enable write
  assert_en_untouched_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 2'b01) |=>
      ((enQ & ~$past(wrData[6:0])) == ($past(enQ) & ~$past(wrData[6:0]))));

  // R10: a timer 1 timeout is always latched
  assert_t1_latched_R10: assert property (@(posedge clk) disable iff (!rstN)
    t1Timeout |=> flagQ[6]);

  // R4: clearing the timer 1 flag works when no timeout competes
  assert_clear_t1_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 2'b00 && !wrData[7] && wrData[6] && !t1Timeout) |=> !flagQ[6]);
endmodule

bind irqFlagUnit irqFlagChk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
  .rdData(rdData), .irqN(irqN), .t1Timeout(t1Timeout),
  .flagQ(flagQ), .enQ(enQ)
);

// File: tb/sim_irqFlagUnit.sv
module sim_irqFlagUnit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regSel = 2'b00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic portAAccess = 0, portBAccess = 0;
  logic ctlA1 = 1, ctlA2In = 1, ctlB1 = 1, ctlB2In = 1;
  logic shiftDone = 0, t1Timeout = 0, t2Timeout = 0;
  logic irqN, ctlA2Out, ctlA2OutEn, ctlB2Out, ctlB2OutEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  bit [6:0] mFlag, mEn;
  bit [7:0] mCtl;
  bit       mPrev [4];   // A1, A2, B1, B2

  always #(CLK_PERIOD/2) clk = ~clk;

  irqFlagUnit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .rdData(rdData), .portAAccess(portAAccess), .portBAccess(portBAccess),
    .ctlA1(ctlA1), .ctlA2In(ctlA2In), .ctlB1(ctlB1), .ctlB2In(ctlB2In),
    .shiftDone(shiftDone), .t1Timeout(t1Timeout), .t2Timeout(t2Timeout),
    .irqN(irqN), .ctlA2Out(ctlA2Out), .ctlA2OutEn(ctlA2OutEn),
    .ctlB2Out(ctlB2Out), .ctlB2OutEn(ctlB2OutEn)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit edgeHit(bit prev, bit cur, bit rising);
    return rising ? (!prev && cur) : (prev && !cur);
  endfunction

  function automatic int modelRead(int sel);
    if (sel == 0) return {((mFlag & mEn) != 0) ? 1 : 0, mFlag};
    if (sel == 1) return {1'b1, mEn};
    if (sel == 2) return mCtl;
    return 0;
  endfunction

  task automatic modelUpdate();
    bit cur [4];
    int modeA, modeB;
    bit [6:0] ev;
    cur[0] = ctlA1; cur[1] = ctlA2In; cur[2] = ctlB1; cur[3] = ctlB2In;
    if (!rstN) begin
      mFlag = 0; mEn = 0; mCtl = 0;
    end else begin
      modeA = mCtl[3:1];
      modeB = mCtl[7:5];
      ev = 0;
      ev[1] = edgeHit(mPrev[0], cur[0], mCtl[0]);
      ev[4] = edgeHit(mPrev[2], cur[2], mCtl[4]);
      if (modeA < 4) ev[0] = edgeHit(mPrev[1], cur[1], modeA >= 2);
      if (modeB < 4) ev[3] = edgeHit(mPrev[3], cur[3], modeB >= 2);
      ev[2] = shiftDone; ev[5] = t2Timeout; ev[6] = t1Timeout;
      if (wrEn && regSel == 0) begin
        if (wrData[7]) mFlag = mFlag | wrData[6:0];
        else           mFlag = mFlag & ~wrData[6:0];
      end
      if (portAAccess && (modeA == 0 || modeA == 2)) mFlag[0] = 0;
      if (portBAccess && (modeB == 0 || modeB == 2)) mFlag[3] = 0;
      mFlag = mFlag | ev;
      if (wrEn && regSel == 1) begin
        if (wrData[7]) mEn = mEn | wrData[6:0];
        else           mEn = mEn & ~wrData[6:0];
      end
      if (wrEn && regSel == 2) mCtl = wrData;
    end
    for (int i = 0; i < 4; i++) mPrev[i] = cur[i];
  endtask

  task automatic compareAll();
    int modeA, modeB;
    modeA = mCtl[3:1];
    modeB = mCtl[7:5];
    check("R2/R5/R11 read", rdData, modelRead(regSel));
    check("R3 irqN", irqN, ((mFlag & mEn) != 0) ? 0 : 1);
    check("R9 A2 drive", {ctlA2OutEn, ctlA2Out}, {modeA >= 4, modeA != 6});
    check("R9 B2 drive", {ctlB2OutEn, ctlB2Out}, {modeB >= 4, modeB != 6});
  endtask

  task automatic tick();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compareAll();
    wrEn = 0; portAAccess = 0; portBAccess = 0;
    shiftDone = 0; t1Timeout = 0; t2Timeout = 0;
  endtask

  task automatic wr(input int sel, input int data);
    regSel = sel[1:0]; wrData = data[7:0]; wrEn = 1;
    tick();
  endtask

  task automatic rdCheck(input string req, input int sel, input int exp);
    regSel = sel[1:0];
    #1;
    check(req, rdData, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    ctlA1 = 0; ctlB2In = 0;    // line activity inside reset must not flag
    tick(); ctlA1 = 1; tick(); tick();
    rstN = 1;
    tick();
    rdCheck("R1 flags after reset", 0, 8'h00);
    rdCheck("R1 enables after reset", 1, 8'h80);
    rdCheck("R1 control after reset", 2, 8'h00);
    check("R1 irqN after reset", irqN, 1);

    // R5: enable all, read back
    wr(1, 8'hFF);
    rdCheck("R5 enable all", 1, 8'hFF);
    // R10/R3: timer 1 timeout raises flag and request
    t1Timeout = 1; regSel = 0; tick();
    rdCheck("R10 timer1 flag", 0, 8'hC0);
    check("R3 irq asserted", irqN, 0);
    // R4: clear timer1 flag
    wr(0, 8'h40);
    rdCheck("R4 clear flag", 0, 8'h00);
    // R4: set shift flag by write; others untouched
    t2Timeout = 1; tick();
    wr(0, 8'h84);
    rdCheck("R4 set flag keeps others", 0, 8'hA4);
    // R5: disable bits 2 and 5 -> request drops, flags remain
    wr(1, 8'h24);
    rdCheck("R5 disable", 1, 8'hDB);
    rdCheck("R2 master clear when masked", 0, 8'h24);
    check("R3 irq released", irqN, 1);
    wr(0, 8'h7F);
    wr(1, 8'hFF);

    // R6: A1 falling by default, then rising
    ctlA1 = 0; tick();
    rdCheck("R6 A1 falling", 0, 8'h82);
    wr(0, 8'h02);
    ctlA1 = 1; tick();
    rdCheck("R6 A1 rising ignored", 0, 8'h00);
    wr(2, 8'h11);                 // A1 and B1 rising
    ctlA1 = 0; ctlB1 = 0; tick();
    rdCheck("R6 falling ignored when rising set", 0, 8'h00);
    ctlA1 = 1; ctlB1 = 1; tick();
    rdCheck("R6 A1 B1 rising", 0, 8'h92);
    wr(0, 8'h12);

    // R7/R8: A2 mode 000 falling, port access clears
    wr(2, 8'h00);
    ctlA2In = 0; tick();
    rdCheck("R7 A2 falling", 0, 8'h81);
    portAAccess = 1; tick();
    rdCheck("R8 port access clears A2", 0, 8'h00);
    // mode 010 rising
    wr(2, 8'h04);
    ctlA2In = 1; tick();
    rdCheck("R7 A2 rising", 0, 8'h81);
    portAAccess = 1; tick();
    rdCheck("R8 port clears in 010", 0, 8'h00);
    // independent mode 011 on A2 and 001 on B2
    wr(2, 8'h26);
    ctlA2In = 0; ctlB2In = 1; tick();
    ctlA2In = 1; ctlB2In = 0; tick();
    rdCheck("R7 A2 011 and B2 001", 0, 8'h89);
    portAAccess = 1; portBAccess = 1; tick();
    rdCheck("R8 independent not cleared", 0, 8'h89);
    wr(0, 8'h09);

    // R9: output modes
    wr(2, 8'hDC);                 // A2 110, B2 110
    check("R9 A2 drive low", {ctlA2OutEn, ctlA2Out}, 2'b10);
    wr(2, 8'hFE);                 // both 111
    check("R9 B2 drive high", {ctlB2OutEn, ctlB2Out}, 2'b11);
    ctlA2In = 0; ctlB2In = 1; tick();
    ctlA2In = 1; ctlB2In = 0; tick();
    rdCheck("R9 no flag in output mode", 0, 8'h00);
    wr(2, 8'h00);

    // R10: event wins over clear in same cycle
    wr(0, 8'hFF);
    regSel = 0; wrData = 8'h7F; wrEn = 1; shiftDone = 1; t1Timeout = 1;
    ctlA2In = 0; portAAccess = 1; tick();
    rdCheck("R10 event beats clear", 0, 8'hC5);

    // R11: unused select
    wr(3, 8'hFF);
    rdCheck("R11 unused reads zero", 3, 8'h00);
    rdCheck("R11 flags unchanged", 0, 8'hC5);
    rdCheck("R11 control unchanged", 2, 8'h00);

    // random mix, compared every cycle
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom;
      wrEn = (r % 4) == 0;
      regSel = 2'($urandom);
      wrData = 8'($urandom);
      portAAccess = (($urandom % 5) == 0);
      portBAccess = (($urandom % 5) == 0);
      ctlA1 = 1'($urandom); ctlA2In = 1'($urandom);
      ctlB1 = 1'($urandom); ctlB2In = 1'($urandom);
      shiftDone = (($urandom % 7) == 0);
      t1Timeout = (($urandom % 9) == 0);
      t2Timeout = (($urandom % 9) == 0);
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule